// File: doc/BRIEF.md
# Compare-Triggered ADC Start Controller

This block paces analog-to-digital conversions in hardware. A free-running timer counts up every clock. When the timer equals a programmable compare value and the compare mode field selects the special event function, the timer returns to zero and, if the converter is enabled, a conversion request is raised. The timer reloads on every such match, so the conversions repeat at a fixed period with no software in the loop.

A request sets a busy flag (GO/DONE). A programmable acquisition delay then runs, after which a one-cycle start pulse goes to an external converter. When the converter reports completion, the busy flag clears and a sticky completion interrupt flag is raised. Software can also launch a conversion by a register write, and this write takes the same delay path. Configuration uses a write-only bus: a write strobe, a 2-bit address and a data word.

Register map: address 0 holds the compare value. Address 1 is the control word, with mode in bits [3:0], enable in bit 4 and acquisition code in bits [7:5]. Address 2 is the command word, where bit 0 launches a conversion and bit 1 clears the interrupt flag. Writes to address 3 have no effect.

Top module: `cmp_adc_trig`

## Requirements
- R1: The special event function is active only while the control mode field (address 1, bits [3:0]) equals 4'b1011.
- R2: When the timer equals the compare value in special mode, the enable bit (address 1, bit 4) is set and GO/DONE is low, GO/DONE is high after the next clock edge.
- R3: In special mode, a timer/compare match makes the timer read zero on the next cycle. Otherwise the timer increments by one per cycle and wraps at its width.
- R4: With the enable bit clear, a special event match still resets the timer, but GO/DONE stays low.
- R5: The acquisition code (address 1, bits [7:5]) values 0 to 7 select 0, 2, 4, 6, 8, 12, 16 and 20 conversion-clock periods of TAD_DIV clocks each. The code is captured at launch. Once GO/DONE rises, adc_start is high for exactly one cycle, D+1 cycles later, where D is the selected delay in clocks.
- R6: When the mode field differs from 4'b1011, a timer/compare match neither resets the timer nor starts a conversion.
- R7: conv_done is accepted while GO/DONE is high and the start pulse has been issued (in the cycle of the pulse or later). It clears GO/DONE and sets cmp_irq on the next cycle. cmp_irq then stays high until a write to address 2 with bit 1 set. A set that coincides with a clear wins. conv_done at any other time is ignored.
- R8: A special event while GO/DONE is high does not restart the acquisition or issue a second start pulse, but it still resets the timer.
- R9: A write to address 2 with bit 0 set launches a conversion like a special event when enabled and idle. It is ignored when the enable bit is clear.
- R10: After reset the timer, GO/DONE, adc_start and cmp_irq are zero, the compare value is all ones, and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | TW | Register write data |
| conv_done | input | 1 | Completion indication from the converter |
| adc_start | output | 1 | One-cycle conversion start pulse |
| go_done | output | 1 | Busy flag, high from launch until completion |
| cmp_irq | output | 1 | Sticky completion interrupt flag |
| tmr_val | output | TW | Current timer value |

## Verification
The timer is visible on tmr_val, so a wrong match or reload decision shows up one cycle after the match: the timer either fails to read zero or reads zero when it should have counted on. A fault in the busy or acquisition sequencer shows as a start pulse in the wrong cycle, a missing or doubled pulse, or GO/DONE failing to rise the cycle after a launch. A sticky flag that drops or fails to set shows on cmp_irq one cycle after the offending conv_done or clear write. A cycle-accurate model in the bench compares all four outputs on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/cat_pkg.sv
package cat_pkg;
   localparam logic [3:0] MODE_SPECIAL = 4'b1011;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACQ  = 2'd1,
      PH_CONV = 2'd2
   } phase_t;

   // conversion-clock periods selected by the 3-bit acquisition code
   function automatic int unsigned acq_periods(input logic [2:0] code);
      case (code)
         3'd0: return 0;
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 6;
         3'd4: return 8;
         3'd5: return 12;
         3'd6: return 16;
         default: return 20;
      endcase
   endfunction
endpackage

// File: rtl/cat_timer.sv
module cat_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] cmp,
   input  logic          special,
   output logic [TW-1:0] tmr,
   output logic          evt
);
   assign evt = special && (tmr == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tmr <= '0;
      else if (evt) tmr <= '0;
      else          tmr <= tmr + 1'b1;
   end
endmodule

// File: rtl/cat_acq_seq.sv
module cat_acq_seq
   import cat_pkg::*;
#(
   parameter int TAD_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [2:0] acq_code,
   input  logic       conv_done,
   output logic       go,
   output logic       start,
   output logic       done_ack
);
   localparam int MAXD = 20 * TAD_DIV;
   localparam int CW   = $clog2(MAXD + 1);

   phase_t        phase;
   logic [CW-1:0] cnt;
   logic [CW-1:0] delay;

   generate
      if (TAD_DIV == 1) begin : g_div1
         assign delay = CW'(acq_periods(acq_code));
      end else begin : g_divn
         assign delay = CW'(acq_periods(acq_code) * TAD_DIV);
      end
   endgenerate

   assign go       = (phase != PH_IDLE);
   assign done_ack = (phase == PH_CONV) && conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         start <= 1'b0;
      end else begin
         start <= 1'b0;
         case (phase)
            PH_IDLE: if (req) begin
               phase <= PH_ACQ;
               cnt   <= delay;
            end
            PH_ACQ: if (cnt == '0) begin
               start <= 1'b1;
               phase <= PH_CONV;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_CONV: if (conv_done) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cmp_adc_trig.sv
module cmp_adc_trig
   import cat_pkg::*;
#(
   parameter int TW      = 16,
   parameter int TAD_DIV = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [TW-1:0] wr_data,
   input  logic          conv_done,
   output logic          adc_start,
   output logic          go_done,
   output logic          cmp_irq,
   output logic [TW-1:0] tmr_val
);
   generate
      if (TW < 8) begin : g_bad_tw
         $error("cmp_adc_trig: TW must be at least 8");
      end
      if (TAD_DIV < 1) begin : g_bad_div
         $error("cmp_adc_trig: TAD_DIV must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cmp_q;
   logic [3:0]    mode_q;
   logic          en_q;
   logic [2:0]    acq_q;
   logic          irq_q;
   logic          evt, done_ack, sw_go, irq_clr, req;

   assign sw_go   = wr_en && (wr_addr == 2'd2) && wr_data[0];
   assign irq_clr = wr_en && (wr_addr == 2'd2) && wr_data[1];
   assign req     = en_q && (evt || sw_go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '1;
         mode_q <= '0;
         en_q   <= 1'b0;
         acq_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            2'd0: cmp_q <= wr_data;
            2'd1: begin
               mode_q <= wr_data[3:0];
               en_q   <= wr_data[4];
               acq_q  <= wr_data[7:5];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_q <= 1'b0;
      else if (done_ack) irq_q <= 1'b1;
      else if (irq_clr)  irq_q <= 1'b0;
   end

   cat_timer #(.TW(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp     (cmp_q),
      .special (mode_q == MODE_SPECIAL),
      .tmr     (tmr_val),
      .evt     (evt)
   );

   cat_acq_seq #(.TAD_DIV(TAD_DIV)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .acq_code  (acq_q),
      .conv_done (conv_done),
      .go        (go_done),
      .start     (adc_start),
      .done_ack  (done_ack)
   );

   assign cmp_irq = irq_q;
endmodule

// File: rtl/cat_chk.sv
module cat_chk #(
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    wr_addr,
   input logic [TW-1:0] wr_data,
   input logic          conv_done,
   input logic          adc_start,
   input logic          go_done,
   input logic          cmp_irq,
   input logic [TW-1:0] tmr_val,
   input logic [TW-1:0] cmp_q,
   input logic [3:0]    mode_q,
   input logic          en_q
);
   a_r3_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_val == cmp_q && mode_q == 4'b1011) |=> (tmr_val == '0));

   a_r6_plain_count: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 4'b1011) |=> (tmr_val == TW'($past(tmr_val) + 1'b1)));

   a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !go_done) |=> !go_done);

   a_r2_event_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_val == cmp_q && mode_q == 4'b1011 && en_q && !go_done) |=> go_done);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

   a_r5_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> go_done);

   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_irq && !(wr_en && wr_addr == 2'd2 && wr_data[1])) |=> cmp_irq);

   a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && conv_done) |=> (!go_done && cmp_irq));
endmodule

bind cmp_adc_trig cat_chk #(.TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .conv_done (conv_done),
   .adc_start (adc_start),
   .go_done   (go_done),
   .cmp_irq   (cmp_irq),
   .tmr_val   (tmr_val),
   .cmp_q     (cmp_q),
   .mode_q    (mode_q),
   .en_q      (en_q)
);

// File: tb/cmp_adc_trig_bench.sv
module cmp_adc_trig_bench;
   localparam int TW  = 16;
   localparam int DIV = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [TW-1:0] wr_data = '0;
   logic          conv_done = 1'b0;
   logic          adc_start, go_done, cmp_irq;
   logic [TW-1:0] tmr_val;

   int n_chk = 0;
   int n_bad = 0;
   bit done_run = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cmp_adc_trig #(.TW(TW), .TAD_DIV(DIV)) u_cmp_adc_trig (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .conv_done(conv_done), .adc_start(adc_start),
      .go_done(go_done), .cmp_irq(cmp_irq), .tmr_val(tmr_val)
   );

   function automatic int delay_clocks(input logic [2:0] code);
      int p;
      case (code)
         3'd0: p = 0;   3'd1: p = 2;   3'd2: p = 4;   3'd3: p = 6;
         3'd4: p = 8;   3'd5: p = 12;  3'd6: p = 16;  default: p = 20;
      endcase
      return p * DIV;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, built from the requirements
   logic [TW-1:0] m_tmr, m_cmp;
   logic [3:0]    m_mode;
   logic          m_en, m_go, m_start, m_irq;
   logic [2:0]    m_acq;
   int            m_ph, m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tmr = '0; m_cmp = '1; m_mode = '0; m_en = 0; m_acq = '0;
         m_go = 0; m_start = 0; m_irq = 0; m_ph = 0; m_cnt = 0;
      end else begin
         bit ev, sw, clr, req, dack;
         ev   = (m_mode == 4'b1011) && (m_tmr == m_cmp);
         sw   = wr_en && wr_addr == 2'd2 && wr_data[0];
         clr  = wr_en && wr_addr == 2'd2 && wr_data[1];
         req  = m_en && (ev || sw);
         dack = (m_ph == 2) && conv_done;
         m_tmr   = ev ? '0 : m_tmr + 1'b1;
         m_start = 0;
         if (m_ph == 0) begin
            if (req) begin m_ph = 1; m_cnt = delay_clocks(m_acq); end
         end else if (m_ph == 1) begin
            if (m_cnt == 0) begin m_start = 1; m_ph = 2; end
            else m_cnt--;
         end else if (conv_done) m_ph = 0;
         m_go = (m_ph != 0);
         if (dack) m_irq = 1; else if (clr) m_irq = 0;
         if (wr_en && wr_addr == 2'd0) m_cmp = wr_data;
         if (wr_en && wr_addr == 2'd1) begin
            m_mode = wr_data[3:0]; m_en = wr_data[4]; m_acq = wr_data[7:5];
         end
      end
   end

   always @(negedge clk) if (rst_n && !done_run) begin
      check("R3 timer",    tmr_val,   m_tmr);
      check("R2 go_done",  go_done,   m_go);
      check("R5 adc_start",adc_start, m_start);
      check("R7 cmp_irq",  cmp_irq,   m_irq);
   end

   task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [TW-1:0] ctrl(input logic [3:0] mode, input bit en,
                                          input logic [2:0] acq);
      return TW'({acq, en, mode});
   endfunction

   initial begin
      void'($urandom(32'h5eed));
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int k, starts, gos;
      logic [TW-1:0] t0;
      repeat (3) @(negedge clk);
      // R10 reset values
      check("R10 timer", tmr_val, 0);
      check("R10 go_done", go_done, 0);
      check("R10 adc_start", adc_start, 0);
      check("R10 cmp_irq", cmp_irq, 0);
      rst_n = 1'b1;

      // R4: disabled, special mode, matches reset the timer only
      wr(2'd0, 16'd20);
      wr(2'd1, ctrl(4'b1011, 0, 3'd0));
      gos = 0; k = 0;
      repeat (60) begin
         @(negedge clk);
         if (go_done) gos++;
         if (tmr_val > k) k = tmr_val;
      end
      check("R4 no go while disabled", gos, 0);
      check("R4 timer bounded by compare", k, 20);

      // R1 R6: mode 1010 never reloads
      wr(2'd1, ctrl(4'b1010, 1, 3'd0));
      repeat (30) @(negedge clk);
      check("R1 R6 timer passes compare", tmr_val > 20, 1);
      check("R6 no launch", go_done, 0);
      t0 = tmr_val;
      wr(2'd0, t0 + 16'd8);
      wr(2'd1, ctrl(4'b1011, 0, 3'd0));

      // R9: software launch ignored when disabled
      wr(2'd2, 16'h0001);
      check("R9 ignored when disabled", go_done, 0);
      t0 = tmr_val;
      wr(2'd0, t0 + 16'd200);
      wr(2'd1, ctrl(4'b1011, 1, 3'd0));
      wr(2'd2, 16'h0001);
      check("R9 software launch", go_done, 1);
      @(negedge clk);
      check("R5 code 0 start next cycle", adc_start, 1);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      check("R7 done clears go", go_done, 0);
      check("R7 done sets irq", cmp_irq, 1);
      repeat (5) @(negedge clk);
      check("R7 irq sticky", cmp_irq, 1);
      wr(2'd2, 16'h0002);
      check("R7 irq cleared by write", cmp_irq, 0);

      // R5: code 3 gives 6 periods
      wr(2'd1, ctrl(4'b1011, 1, 3'd3));
      wr(2'd2, 16'h0001);
      k = 0;
      while (!adc_start && k < 100) begin @(negedge clk); k++; end
      check("R5 code 3 latency", k, delay_clocks(3'd3) + 1);
      @(negedge clk);
      check("R5 pulse one cycle", adc_start, 0);
      conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
      wr(2'd2, 16'h0002);

      // R8: frequent events while a long acquisition runs
      t0 = tmr_val;
      wr(2'd0, t0 + 16'd4);
      wr(2'd1, ctrl(4'b1011, 1, 3'd7));
      starts = 0;
      repeat (delay_clocks(3'd7) + 20) begin
         @(negedge clk);
         if (adc_start) starts++;
      end
      check("R8 single start under repeated events", starts, 1);
      check("R8 timer still reloads", tmr_val <= t0 + 16'd4, 1);
      conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;

      // random phase, checked by the model every cycle
      for (int i = 0; i < 15000; i++) begin
         @(negedge clk);
         conv_done = ($urandom % 4) == 0;
         wr_en = 1'b0; wr_data = '0;
         if (($urandom % 12) == 0) begin
            int r;
            r = $urandom % 4;
            wr_en = 1'b1;
            wr_addr = 2'(r);
            case (r)
               0: wr_data = tmr_val + 16'd3 + 16'($urandom % 50);
               1: wr_data = ctrl((($urandom % 4) != 0) ? 4'b1011 : 4'($urandom),
                                 (($urandom % 4) != 0), 3'($urandom));
               default: wr_data = TW'($urandom);
            endcase
         end
      end
      @(negedge clk);
      wr_en = 1'b0; conv_done = 1'b0;
      repeat (2) @(negedge clk);
      done_run = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule